// File: doc/BRIEF.md
# Phase-Window Lock Qualifier with Holdover

This block watches the two edge streams that feed a phase detector, a reference and a feedback, each given as a one-cycle pulse synchronous to a fast system clock. For every pair of edges it counts how many system-clock cycles separate them. It then judges the pair good or bad against a programmable phase window. A run of consecutive good pairs raises a lock flag. The length of that run is programmable, and it differs depending on whether the block starts from the unlocked state or from holdover.

A loss-of-signal input moves a locked block into holdover. It stays in holdover until a fresh run of good pairs proves that the reference again matches the loop. A reference that comes back at the wrong frequency keeps producing bad pairs, so the block stays in holdover. The window and both run lengths are taken from configuration inputs only when a load strobe is pulsed. They go into use the next time the qualification run is at zero.

Top module: `lock_detect_holdover`

## Requirements
- R1: A synchronous reset, active high, puts the block in the unlocked state (`state_o` = 0) with both flags low and the run counter cleared. It also restores the default window (4), lock run (8) and holdover run (16).
- R2: Skew is the number of system-clock cycles from the first edge of a pair to the partner edge on the other input, whichever input leads. Edges in the same cycle have skew 0. A pair is good only if its skew is strictly less than the active window.
- R3: If the leading input pulses again before its partner arrives, that pair is judged bad and the new pulse starts a new measurement.
- R4: In the unlocked state, the block enters the locked state (`state_o` = 1, `lock_o` high) on the clock edge that samples the good pair completing a run of lock-run consecutive good pairs.
- R5: A bad pair before the run completes clears the run counter to zero, and qualification starts over.
- R6: In the locked state, a bad pair while loss of signal is low returns the block to the unlocked state on the next clock edge.
- R7: In the locked state, loss of signal high moves the block to holdover (`state_o` = 2, `holdover_o` high, `lock_o` low) on the next clock edge.
- R8: In holdover with loss of signal low, the block returns to locked only after holdover-run consecutive good pairs. Any bad pair keeps the block in holdover and clears the run.
- R9: The configuration inputs have no effect unless `cfg_load` is pulsed. A loaded set becomes active on a clock edge at which the run counter is zero afterwards.
- R10: `lock_o` and `holdover_o` are never high together. Both follow `state_o`, which uses 0 for unlocked, 1 for locked and 2 for holdover.
- R11: Loss of signal high in the unlocked state clears the run counter, and no transition takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | One-cycle pulse per reference edge |
| fb_pulse | input | 1 | One-cycle pulse per feedback edge |
| los | input | 1 | Reference loss-of-signal level |
| cfg_load | input | 1 | Strobe that captures the three configuration inputs |
| cfg_window | input | WIN_W | Phase window in system-clock cycles |
| cfg_lock_run | input | CNT_W | Good pairs needed to lock from unlocked |
| cfg_hold_run | input | CNT_W | Good pairs needed to leave holdover |
| lock_o | output | 1 | Lock flag |
| holdover_o | output | 1 | Holdover flag |
| state_o | output | 2 | Current state: 0 unlocked, 1 locked, 2 holdover |

## Verification
A pair is judged in the cycle in which its completing edge is sampled. The resulting state and flag change appears at the clock edge that samples that edge, with no further latency, and a loss-of-signal level acts on the very next edge. A loaded configuration becomes active one edge after the strobe, at the earliest. The bench drives pulses just after the falling edge. A behavioural model is stepped at each rising edge and compared with the outputs at the next falling edge, so every result is checked in the exact cycle it is due. Named checks after each stimulus phase confirm the counts, the window boundary and the holdover exit.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
    typedef enum logic [1:0] {
        ST_UNLOCK = 2'd0,
        ST_LOCKED = 2'd1,
        ST_HOLD   = 2'd2
    } lkd_state_e;
endpackage

// File: rtl/lkd_skew_meter.sv
module lkd_skew_meter #(
    parameter int WIN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_pulse,
    input  logic             fb_pulse,
    input  logic [WIN_W-1:0] win,
    output logic             meas_valid,
    output logic             meas_good
);
    localparam int AGE_W = WIN_W + 1;

    typedef struct packed {
        logic             waiting;
        logic             ref_first;
        logic [AGE_W-1:0] age;
    } meter_t;

    meter_t cur_q, nxt_d;
    logic lead_hit, partner_hit;
    logic [AGE_W-1:0] win_ext;

    always_comb begin
        nxt_d       = cur_q;
        meas_valid  = 1'b0;
        meas_good   = 1'b0;
        win_ext     = {1'b0, win};
        lead_hit    = cur_q.ref_first ? ref_pulse : fb_pulse;
        partner_hit = cur_q.ref_first ? fb_pulse : ref_pulse;
        if (!cur_q.waiting) begin
            if (ref_pulse && fb_pulse) begin
                meas_valid = 1'b1;
                meas_good  = (win != '0);
            end else if (ref_pulse || fb_pulse) begin
                nxt_d.waiting   = 1'b1;
                nxt_d.ref_first = ref_pulse;
                nxt_d.age       = AGE_W'(1);
            end
        end else if (partner_hit) begin
            meas_valid = 1'b1;
            meas_good  = (cur_q.age < win_ext);
            if (lead_hit) nxt_d.age = AGE_W'(1);
            else          nxt_d.waiting = 1'b0;
        end else if (lead_hit) begin
            meas_valid = 1'b1;
            meas_good  = 1'b0;
            nxt_d.age  = AGE_W'(1);
        end else if (cur_q.age <= win_ext) begin
            nxt_d.age = cur_q.age + AGE_W'(1);
        end
        if (rst) nxt_d = '0;
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.waiting && !ref_pulse && !fb_pulse)
        |=> (cur_q.waiting && cur_q.age >= $past(cur_q.age)));

    // R3
    lead_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.waiting && cur_q.ref_first && ref_pulse && !fb_pulse)
        |-> (meas_valid && !meas_good));
endmodule

// File: rtl/lkd_qual_fsm.sv
module lkd_qual_fsm
    import lkd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             meas_valid,
    input  logic             meas_good,
    input  logic             los,
    input  logic [CNT_W-1:0] lock_run,
    input  logic [CNT_W-1:0] hold_run,
    output logic [1:0]       state_o,
    output logic             restart_o
);
    typedef struct packed {
        lkd_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        nxt_d   = cur_q;
        cnt_inc = {1'b0, cur_q.cnt} + (CNT_W+1)'(1);
        case (cur_q.st)
            ST_UNLOCK: begin
                if (los) begin
                    nxt_d.cnt = '0;
                end else if (meas_valid) begin
                    if (!meas_good) begin
                        nxt_d.cnt = '0;
                    end else if (cnt_inc >= {1'b0, lock_run}) begin
                        nxt_d.st  = ST_LOCKED;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.cnt = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            ST_LOCKED: begin
                nxt_d.cnt = '0;
                if (los)                          nxt_d.st = ST_HOLD;
                else if (meas_valid && !meas_good) nxt_d.st = ST_UNLOCK;
            end
            ST_HOLD: begin
                if (los) begin
                    nxt_d.cnt = '0;
                end else if (meas_valid) begin
                    if (!meas_good) begin
                        nxt_d.cnt = '0;
                    end else if (cnt_inc >= {1'b0, hold_run}) begin
                        nxt_d.st  = ST_LOCKED;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.cnt = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            default: begin
                nxt_d.st  = ST_UNLOCK;
                nxt_d.cnt = '0;
            end
        endcase
        if (rst) begin
            nxt_d.st  = ST_UNLOCK;
            nxt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign state_o   = cur_q.st;
    assign restart_o = (nxt_d.cnt == '0);

    // R5
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_UNLOCK && lock_run != '0) |-> (cur_q.cnt < lock_run));

    // R6
    drop_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_LOCKED && !los && meas_valid && !meas_good)
        |=> (cur_q.st == ST_UNLOCK));

    // R7
    hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_HOLD && $past(cur_q.st) != ST_HOLD)
        |-> $past(cur_q.st == ST_LOCKED && los));

    // R8
    hold_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_HOLD && meas_valid && !meas_good)
        |=> (cur_q.st == ST_HOLD && cur_q.cnt == '0));
endmodule

// File: rtl/lkd_cfg_shadow.sv
module lkd_cfg_shadow #(
    parameter int WIN_W      = 6,
    parameter int CNT_W      = 8,
    parameter int DEF_WINDOW = 4,
    parameter int DEF_LOCK   = 8,
    parameter int DEF_HOLD   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIN_W-1:0] in_win,
    input  logic [CNT_W-1:0] in_lock,
    input  logic [CNT_W-1:0] in_hold,
    input  logic             restart,
    output logic [WIN_W-1:0] act_win,
    output logic [CNT_W-1:0] act_lock,
    output logic [CNT_W-1:0] act_hold
);
    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [CNT_W-1:0] lock;
        logic [CNT_W-1:0] hold;
    } cfg_t;

    localparam cfg_t CFG_RST = '{win:  WIN_W'(DEF_WINDOW),
                                 lock: CNT_W'(DEF_LOCK),
                                 hold: CNT_W'(DEF_HOLD)};

    cfg_t pend_q, pend_d, act_q, act_d;

    always_comb begin
        pend_d = pend_q;
        act_d  = act_q;
        if (restart) act_d = pend_q;
        if (load) begin
            pend_d.win  = in_win;
            pend_d.lock = in_lock;
            pend_d.hold = in_hold;
        end
        if (rst) begin
            pend_d = CFG_RST;
            act_d  = CFG_RST;
        end
    end

    always_ff @(posedge clk) begin
        pend_q <= pend_d;
        act_q  <= act_d;
    end

    assign act_win  = act_q.win;
    assign act_lock = act_q.lock;
    assign act_hold = act_q.hold;

    // R9
    pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pend_q));

    // R9
    act_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $stable(act_q));
endmodule

// File: rtl/lock_detect_holdover.sv
module lock_detect_holdover
    import lkd_pkg::*;
#(
    parameter int WIN_W      = 6,
    parameter int CNT_W      = 8,
    parameter int DEF_WINDOW = 4,
    parameter int DEF_LOCK   = 8,
    parameter int DEF_HOLD   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_pulse,
    input  logic             fb_pulse,
    input  logic             los,
    input  logic             cfg_load,
    input  logic [WIN_W-1:0] cfg_window,
    input  logic [CNT_W-1:0] cfg_lock_run,
    input  logic [CNT_W-1:0] cfg_hold_run,
    output logic             lock_o,
    output logic             holdover_o,
    output logic [1:0]       state_o
);
    logic             meas_valid, meas_good, restart;
    logic [WIN_W-1:0] act_win;
    logic [CNT_W-1:0] act_lock, act_hold;
    logic [1:0]       st;

    lkd_cfg_shadow #(
        .WIN_W(WIN_W), .CNT_W(CNT_W), .DEF_WINDOW(DEF_WINDOW),
        .DEF_LOCK(DEF_LOCK), .DEF_HOLD(DEF_HOLD)
    ) u_cfg (
        .clk(clk), .rst(rst), .load(cfg_load), .in_win(cfg_window),
        .in_lock(cfg_lock_run), .in_hold(cfg_hold_run), .restart(restart),
        .act_win(act_win), .act_lock(act_lock), .act_hold(act_hold)
    );

    lkd_skew_meter #(.WIN_W(WIN_W)) u_meter (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .win(act_win), .meas_valid(meas_valid), .meas_good(meas_good)
    );

    lkd_qual_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_good(meas_good),
        .los(los), .lock_run(act_lock), .hold_run(act_hold),
        .state_o(st), .restart_o(restart)
    );

    assign state_o    = st;
    assign lock_o     = (st == ST_LOCKED);
    assign holdover_o = (st == ST_HOLD);

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lock_o && holdover_o));

    // R10
    state_code_chk: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'd3);
endmodule

// File: tb/tb_lock_detect_holdover.sv
module tb_lock_detect_holdover;
    localparam int PER = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_pulse = 1'b0, fb_pulse = 1'b0, los = 1'b0, cfg_load = 1'b0;
    logic [5:0] cfg_window = 6'd4;
    logic [7:0] cfg_lock_run = 8'd8, cfg_hold_run = 8'd16;
    logic lock_o, holdover_o;
    logic [1:0] state_o;

    always #5 clk = ~clk;

    lock_detect_holdover #(
        .WIN_W(6), .CNT_W(8), .DEF_WINDOW(4), .DEF_LOCK(8), .DEF_HOLD(16)
    ) dut (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .los(los), .cfg_load(cfg_load), .cfg_window(cfg_window),
        .cfg_lock_run(cfg_lock_run), .cfg_hold_run(cfg_hold_run),
        .lock_o(lock_o), .holdover_o(holdover_o), .state_o(state_o)
    );

    int total = 0, bad = 0;
    bit started = 0, done = 0;
    string cur_req = "R1";

    // behavioural model state
    int m_wait = 0, m_age = 0, m_st = 0, m_cnt = 0;
    int pw = 4, pl = 8, ph = 16, aw = 4, al = 8, ah = 16;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit v, g, a, p;
        v = 0; g = 0;
        if (rst) begin
            m_wait = 0; m_age = 0; m_st = 0; m_cnt = 0;
            pw = 4; pl = 8; ph = 16; aw = 4; al = 8; ah = 16;
        end else begin
            if (m_wait == 0) begin
                if (ref_pulse && fb_pulse) begin v = 1; g = (0 < aw); end
                else if (ref_pulse) begin m_wait = 1; m_age = 1; end
                else if (fb_pulse) begin m_wait = 2; m_age = 1; end
            end else begin
                a = (m_wait == 1) ? ref_pulse : fb_pulse;
                p = (m_wait == 1) ? fb_pulse : ref_pulse;
                if (p) begin
                    v = 1; g = (m_age < aw);
                    if (a) m_age = 1; else m_wait = 0;
                end else if (a) begin
                    v = 1; g = 0; m_age = 1;
                end else if (m_age <= aw) m_age++;
            end
            case (m_st)
                0: if (los) m_cnt = 0;
                   else if (v) begin
                       if (!g) m_cnt = 0;
                       else if (m_cnt + 1 >= al) begin m_st = 1; m_cnt = 0; end
                       else m_cnt++;
                   end
                1: begin
                       m_cnt = 0;
                       if (los) m_st = 2;
                       else if (v && !g) m_st = 0;
                   end
                default: if (los) m_cnt = 0;
                   else if (v) begin
                       if (!g) m_cnt = 0;
                       else if (m_cnt + 1 >= ah) begin m_st = 1; m_cnt = 0; end
                       else m_cnt++;
                   end
            endcase
            if (m_cnt == 0) begin aw = pw; al = pl; ah = ph; end
            if (cfg_load) begin pw = cfg_window; pl = cfg_lock_run; ph = cfg_hold_run; end
        end
        started <= 1'b1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk(state_o == 2'(m_st), cur_req, state_o, m_st);
            chk(lock_o == (m_st == 1) && holdover_o == (m_st == 2), cur_req,
                {lock_o, holdover_o}, {(m_st == 1), (m_st == 2)});
            // R10 exclusive flags
            chk(!(lock_o && holdover_o), "R10", {lock_o, holdover_o}, 0);
        end
    end

    task automatic periods(input int n, input int rofs, input int fofs, input bit fon);
        for (int k = 0; k < n; k++)
            for (int c = 0; c < PER; c++) begin
                @(negedge clk);
                ref_pulse = (c == rofs);
                fb_pulse  = fon && (c == fofs);
            end
        @(negedge clk);
        ref_pulse = 0; fb_pulse = 0;
    endtask

    task automatic expect_state(input int exp, input string req);
        chk(state_o == 2'(exp), req, state_o, exp);
        chk(lock_o == (exp == 1), req, lock_o, (exp == 1));
        chk(holdover_o == (exp == 2), req, holdover_o, (exp == 2));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        expect_state(0, "R1");

        // R9: inputs changed without load must be ignored
        cur_req = "R4";
        cfg_window = 6'd1; cfg_lock_run = 8'd2; cfg_hold_run = 8'd2;
        periods(7, 0, 2, 1);
        expect_state(0, "R4");
        expect_state(0, "R9");
        periods(1, 0, 2, 1);
        expect_state(1, "R4");

        // R2 boundary: skew equal to window is bad
        cur_req = "R2";
        periods(1, 0, 4, 1);
        expect_state(0, "R6");

        // R5 abort and restart
        cur_req = "R5";
        periods(5, 0, 3, 1);
        periods(1, 0, 10, 1);
        periods(7, 0, 3, 1);
        expect_state(0, "R5");
        periods(1, 0, 3, 1);
        expect_state(1, "R5");

        // R2 feedback leading
        cur_req = "R2";
        periods(3, 2, 0, 1);
        expect_state(1, "R2");

        // R7 holdover entry
        cur_req = "R7";
        @(negedge clk); los = 1;
        repeat (2) @(negedge clk);
        expect_state(2, "R7");
        los = 0;

        // R3 / R8: missing partner and wrong frequency keep holdover
        cur_req = "R3";
        periods(4, 0, 0, 0);
        expect_state(2, "R3");
        cur_req = "R8";
        periods(6, 0, 7, 1);
        expect_state(2, "R8");
        periods(15, 0, 1, 1);
        expect_state(2, "R8");
        periods(1, 0, 1, 1);
        expect_state(1, "R8");

        // R9 load new configuration
        cur_req = "R9";
        cfg_window = 6'd2; cfg_lock_run = 8'd3; cfg_hold_run = 8'd2;
        @(negedge clk); cfg_load = 1;
        @(negedge clk); cfg_load = 0;
        repeat (3) @(negedge clk);
        periods(1, 0, 2, 1);
        expect_state(0, "R9");
        periods(2, 0, 1, 1);
        expect_state(0, "R9");
        periods(1, 0, 1, 1);
        expect_state(1, "R9");

        // R11 loss of signal in unlocked clears the run
        cur_req = "R11";
        periods(1, 0, 5, 1);
        expect_state(0, "R6");
        periods(2, 0, 1, 1);
        @(negedge clk); los = 1;
        @(negedge clk); los = 0;
        expect_state(0, "R11");
        periods(2, 0, 1, 1);
        expect_state(0, "R11");
        periods(1, 0, 1, 1);
        expect_state(1, "R11");

        // R1 reset from locked
        cur_req = "R1";
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        expect_state(0, "R1");
        repeat (2) @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule